// File: doc/BRIEF.md
# Asynchronous Write Cycle Capture

This block sits between the pins of an asynchronous parallel memory bus and a command controller that runs on a fast system clock. It samples the active-low chip-enable, write-enable and output-enable strobes, together with the address and data pins, through a two-flop synchronizer. It decides which bus activity is a genuine write cycle and turns each one into a single-clock strobe that carries the captured address and data.

A write window is open only while chip-enable and write-enable are both low and output-enable is high. The address is taken when the window opens, which is the later of the two falling strobes. The data is taken from the last clock of the window, which ends at the earlier of the two rising strobes. A window shorter than a set number of clocks is treated as noise. A window that output-enable closes is discarded. All bus activity is ignored until a synchronous power-good input has been high for a set number of clocks. A strobe pair that is already active when the block becomes ready must be released before a write can be accepted.

Top module: `bus_write_capture`

## Requirements
- R1: While rst_ni is low, and at the first clock after it is released, wr_valid_o is 0 and wr_addr_o and wr_data_o are all zeros.
- R2: A write window is a period in which ce_n_i=0, we_n_i=0 and oe_n_i=1. If such a window lasts at least MIN_CLKS (default 3) clocks and ends with ce_n_i or we_n_i rising while oe_n_i stays 1, exactly one wr_valid_o pulse follows, one clock wide.
- R3: wr_addr_o carries the value addr_i had in the first clock of the window, which is the later of the two falling edges. Later address changes within the window are not captured.
- R4: wr_data_o carries the value data_i had in the last clock of the window, before the earlier of the two rising edges. Earlier data values within the window are overwritten.
- R5: A window shorter than MIN_CLKS clocks produces no pulse (glitch rejection).
- R6: If oe_n_i goes low while ce_n_i and we_n_i are both low, the window is discarded and produces no pulse. With oe_n_i low, no window opens.
- R7: No pulse is produced until pwr_good_i has been high for PWR_WAIT_CLKS (default 16) consecutive clocks. A low level on pwr_good_i restarts this wait, and it suppresses wr_valid_o from the second clock after it.
- R8: If the strobes already form a window when the power-good wait completes, that window is ignored. The strobes must leave the write state before a window is accepted.
- R9: wr_addr_o and wr_data_o hold their values in every clock in which wr_valid_o is 0.
- R10: With SYNC_STAGES=2, wr_valid_o is high in the clock that follows the third rising clock edge after the pin edge that ends an accepted window, counting the first rising edge after that pin edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_good_i | input | 1 | Synchronous power-good level |
| ce_n_i | input | 1 | Bus chip enable, active low, asynchronous |
| we_n_i | input | 1 | Bus write enable, active low, asynchronous |
| oe_n_i | input | 1 | Bus output enable, active low, asynchronous |
| addr_i | input | 17 | Bus address, asynchronous |
| data_i | input | 8 | Bus data, asynchronous |
| wr_valid_o | output | 1 | One-clock strobe for each accepted write |
| wr_addr_o | output | 17 | Captured write address |
| wr_data_o | output | 8 | Captured write data |

## Verification
A wrong window state shows at the ports as a missing pulse, an extra pulse or a pulse two clocks wide. Each of these appears within three clocks after the strobe pin that ends the window. A wrong capture register shows as a wrong address or data value on that same pulse. The bench compares the pulse count and the captured values after every cycle it drives. A fault in the power-good wait shows as a pulse during the wait, or as a missing pulse after it. The bench places writes on both sides of the point where the wait ends.

// File: rtl/wcap_pkg.sv
package wcap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,  // waiting for ready and released strobes
    ST_ARMED  = 2'd1,  // ready, strobes inactive
    ST_ACTIVE = 2'd2   // write window open
  } cap_state_e;

  // write window: both strobes low, output enable high
  function automatic logic win_open(logic ce_n, logic we_n, logic oe_n);
    return ~ce_n & ~we_n & oe_n;
  endfunction

endpackage

// File: rtl/wcap_sync.sv
module wcap_sync #(
  parameter int unsigned      WIDTH   = 1,
  parameter int unsigned      STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  localparam int unsigned NST = (STAGES < 2) ? 2 : STAGES;

  logic [WIDTH-1:0] stage_q [NST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NST; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < NST; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[NST-1];

endmodule

// File: rtl/wcap_pwr_gate.sv
module wcap_pwr_gate #(
  parameter int unsigned WAIT_CLKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  output logic ready_o
);

  localparam int unsigned CW = $clog2(WAIT_CLKS + 1);
  localparam logic [CW-1:0] WAIT_END = CW'(WAIT_CLKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!pwr_good_i)        cnt_q <= '0;
    else if (cnt_q != WAIT_END)  cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = (cnt_q == WAIT_END);

endmodule

// File: rtl/wcap_qualify.sv
module wcap_qualify
  import wcap_pkg::*;
#(
  parameter int unsigned ADDR_W   = 17,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MIN_CLKS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ready_i,
  input  logic              ce_n_i,
  input  logic              we_n_i,
  input  logic              oe_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              act_o,
  output logic              emit_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  localparam int unsigned MIN_N = (MIN_CLKS < 1) ? 1 : MIN_CLKS;
  localparam int unsigned CW    = $clog2(MIN_N + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MIN_N);

  cap_state_e        state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              act;
  logic              end_ok;

  assign act    = win_open(ce_n_i, we_n_i, oe_n_i);
  // window closed by a strobe rising, not by output enable
  assign end_ok = !act && oe_n_i && (cnt_q == CNT_MAX);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    addr_d  = addr_q;
    data_d  = data_q;
    emit_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ready_i && !act) state_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (!ready_i) begin
          state_d = ST_IDLE;
        end else if (act) begin
          state_d = ST_ACTIVE;
          cnt_d   = CW'(1);
          addr_d  = addr_i;
          data_d  = data_i;
        end
      end
      ST_ACTIVE: begin
        if (!ready_i) begin
          state_d = ST_IDLE;
        end else if (act) begin
          data_d = data_i;
          if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
        end else if (!oe_n_i) begin
          state_d = ST_IDLE;
        end else begin
          state_d = ST_ARMED;
          emit_o  = end_ok;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
    end
  end

  assign act_o  = act;
  assign addr_o = addr_q;
  assign data_o = data_q;

endmodule

// File: rtl/bus_write_capture.sv
module bus_write_capture #(
  parameter int unsigned ADDR_W        = 17,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned MIN_CLKS      = 3,
  parameter int unsigned PWR_WAIT_CLKS = 16,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_good_i,
  input  logic              ce_n_i,
  input  logic              we_n_i,
  input  logic              oe_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);

  localparam int unsigned BUS_W = ADDR_W + DATA_W;

  logic [2:0]        ctl_s;
  logic [BUS_W-1:0]  bus_s;
  logic              ce_n_s, we_n_s, oe_n_s;
  logic              pwr_ready;
  logic              strobe_act;
  logic              emit;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;

  wcap_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b111)
  ) i_ctl_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ce_n_i, we_n_i, oe_n_i}),
    .q_o   (ctl_s)
  );

  wcap_sync #(
    .WIDTH  (BUS_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL('0)
  ) i_bus_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({addr_i, data_i}),
    .q_o   (bus_s)
  );

  assign {ce_n_s, we_n_s, oe_n_s} = ctl_s;

  wcap_pwr_gate #(
    .WAIT_CLKS(PWR_WAIT_CLKS)
  ) i_pwr_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwr_good_i(pwr_good_i),
    .ready_o   (pwr_ready)
  );

  wcap_qualify #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .MIN_CLKS(MIN_CLKS)
  ) i_qualify (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ready_i(pwr_ready),
    .ce_n_i (ce_n_s),
    .we_n_i (we_n_s),
    .oe_n_i (oe_n_s),
    .addr_i (bus_s[BUS_W-1:DATA_W]),
    .data_i (bus_s[DATA_W-1:0]),
    .act_o  (strobe_act),
    .emit_o (emit),
    .addr_o (cap_addr),
    .data_o (cap_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_valid_o <= emit;
      if (emit) begin
        wr_addr_o <= cap_addr;
        wr_data_o <= cap_data;
      end
    end
  end

endmodule

// File: rtl/wcap_chk.sv
module wcap_chk #(
  parameter int unsigned ADDR_W   = 17,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MIN_CLKS = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pwr_good_i,
  input logic              act_i,
  input logic              oe_n_s_i,
  input logic              wr_valid_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [DATA_W-1:0] wr_data_o
);

  localparam int unsigned CW = $clog2(MIN_CLKS + 2);
  localparam logic [CW-1:0] RUN_MAX = CW'(MIN_CLKS);

  logic [CW-1:0] run_q, held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      held_q <= '0;
    end else begin
      if (act_i) begin
        if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
      end else begin
        run_q <= '0;
        if (run_q != '0) held_q <= run_q;
      end
    end
  end

  // R2
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);

  // R5
  min_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> (held_q >= RUN_MAX));

  // R6
  oe_inhibit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> $past(oe_n_s_i));

  // R7
  pwr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> ##1 !wr_valid_o);

  // R9
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_o |-> ($stable(wr_addr_o) && $stable(wr_data_o)));

endmodule

bind bus_write_capture wcap_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .MIN_CLKS(MIN_CLKS)
) i_wcap_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pwr_good_i(pwr_good_i),
  .act_i     (strobe_act),
  .oe_n_s_i  (oe_n_s),
  .wr_valid_o(wr_valid_o),
  .wr_addr_o (wr_addr_o),
  .wr_data_o (wr_data_o)
);

// File: tb/test_bus_write_capture.sv
`timescale 1ns/1ps
module test_bus_write_capture;

  localparam int MIN_CLKS = 3;
  localparam int PWR_WAIT = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pwr_good = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [16:0] addr = '0;
  logic [7:0]  data = '0;
  logic        wr_valid;
  logic [16:0] wr_addr;
  logic [7:0]  wr_data;

  int checks = 0, failures = 0;
  int pulses = 0, wide_pulses = 0;
  logic        prev_valid = 1'b0;
  logic [16:0] last_addr = '0;
  logic [7:0]  last_data = '0;
  int exp_pulses = 0;
  logic [16:0] exp_addr = '0;
  logic [7:0]  exp_data = '0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  bus_write_capture i_bus_write_capture (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_good_i(pwr_good),
    .ce_n_i(ce_n), .we_n_i(we_n), .oe_n_i(oe_n),
    .addr_i(addr), .data_i(data),
    .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  always @(negedge clk) begin
    if (wr_valid) begin
      pulses++;
      last_addr = wr_addr;
      last_data = wr_data;
      if (prev_valid) wide_pulses++;
    end
    prev_valid = wr_valid;
  end

  function automatic bit exp_accept(int len, bit abort, bit ready);
    return ready && !abort && (len >= MIN_CLKS);
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [16:0] a, logic [7:0] d, int len, bit abort);
    @(negedge clk); addr = a; data = d; ce_n = 1'b0;
    @(negedge clk); we_n = 1'b0;
    repeat (len) @(negedge clk);
    if (abort) begin oe_n = 1'b0; @(negedge clk); end
    we_n = 1'b1; data = ~d;
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic run_write(string req, logic [16:0] a, logic [7:0] d, int len, bit abort, bit ready);
    bus_write(a, d, len, abort);
    if (exp_accept(len, abort, ready)) begin
      exp_pulses++; exp_addr = a; exp_data = d;
    end
    check({req, " count"}, pulses, exp_pulses);
    check({req, " addr"}, last_addr, exp_addr);
    check({req, " data"}, last_data, exp_data);
  endtask

  initial begin
    void'($urandom(32'h5eed_2a11));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", wr_valid, 0);
    check("R1 addr", wr_addr, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 data after release", wr_data, 0);

    // R7 no power good
    run_write("R7 pwr low", 17'h0abcd, 8'h5a, 4, 0, 0);
    pwr_good = 1'b1;
    repeat (2) @(negedge clk);
    run_write("R7 during wait", 17'h01111, 8'h11, 4, 0, 0);

    // R8 strobes held through end of wait
    pwr_good = 1'b0;
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = 17'h1f00f; data = 8'hee;
    @(negedge clk); pwr_good = 1'b1;
    repeat (PWR_WAIT + 6) @(negedge clk);
    we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R8 held strobes", pulses, exp_pulses);

    // R2 basic write after ready
    run_write("R2 basic", 17'h12345, 8'ha5, 4, 0, 1);
    // R5 boundary
    run_write("R5 short", 17'h00001, 8'h01, MIN_CLKS - 1, 0, 1);
    run_write("R5 exact", 17'h1ffff, 8'hff, MIN_CLKS, 0, 1);
    // R6 output enable abort
    run_write("R6 oe abort", 17'h00770, 8'h77, 5, 1, 1);
    // R6 oe low whole time
    @(negedge clk); oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
    repeat (6) @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
    @(negedge clk); oe_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R6 oe low", pulses, exp_pulses);

    // R3/R4 late falling edge address, last-clock data, and R10 latency
    @(negedge clk); addr = 17'h0aaaa; data = 8'h10; ce_n = 1'b0;
    repeat (2) @(negedge clk); addr = 17'h15555; we_n = 1'b0;
    @(negedge clk); addr = 17'h00003; data = 8'h20;
    repeat (2) @(negedge clk); data = 8'h3c;
    repeat (2) @(negedge clk); ce_n = 1'b1; data = 8'hc3;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R10 not yet", wr_valid, 0);
    @(posedge clk); @(negedge clk);
    check("R10 pulse", wr_valid, 1);
    @(negedge clk); we_n = 1'b1;
    check("R2 one wide", wr_valid, 0);
    repeat (5) @(negedge clk);
    exp_pulses++; exp_addr = 17'h15555; exp_data = 8'h3c;
    check("R3 later fall addr", last_addr, exp_addr);
    check("R4 last data", last_data, exp_data);
    check("R9 hold addr", wr_addr, exp_addr);

    // R7 drop restarts wait
    pwr_good = 1'b0; @(negedge clk); pwr_good = 1'b1;
    run_write("R7 rewait", 17'h04444, 8'h44, 4, 0, 0);
    repeat (PWR_WAIT + 4) @(negedge clk);

    // random mix
    for (int i = 0; i < 40; i++) begin
      logic [16:0] a = 17'($urandom);
      logic [7:0]  d = 8'($urandom);
      int          len = 1 + int'($urandom % 6);
      bit          ab = ($urandom % 5) == 0;
      run_write("R2 random", a, d, len, ab, 1);
    end
    check("R2 no wide pulses", wide_pulses, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule